// File: doc/BRIEF.md
# Flip-flop toggle correlation profiler

This block watches a bus of flip-flop outputs during a measurement window and collects the numbers needed to decide which flip-flops can sensibly share one clock gater. For every accepted sample after the first, it forms an activity vector. An activity bit is 1 when that flip-flop's value differs from the previous accepted sample. The block keeps one toggle counter per bit. It also keeps one counter per candidate gating group, and that counter accumulates the clock pulses a shared gater would deliver to members that did not need them.

Software writes one membership mask per group, sets the window length and pulses start. It then streams samples in and reads the results through an address/data read port once done is high. Choosing the groups, for example by matching highly correlated pairs, is left to software. A pair's redundant pulses (the count of XOR of the two activity bits) and its joint activity (the count of their OR) both come from a two-member group and the two bit counters.

Samples arrive on a valid/ready stream. A sample is accepted on a clock edge where `obs_valid_i` and `obs_ready_o` are both high. Ready is high only while a window is running, so a sample offered while idle or after done is dropped and has no effect. The producer may hold valid low on any cycle. Those cycles count toward nothing.

Top module: `tcp_profiler`

## Requirements
- R1: After reset, `done_o` and `obs_ready_o` are 0 and every read address returns 0.
- R2: A start pulse clears every counter, captures the group masks and the window length T, and drops `done_o`. From the next cycle, `obs_ready_o` is 1 when T is nonzero.
- R3: The first accepted sample after start only records the previous value. It adds nothing to any counter and does not count toward the window.
- R4: On each later accepted sample, the toggle counter of bit i grows by 1 when bit i differs from the previous accepted sample. Cycles with valid low change nothing and do not update the previous value.
- R5: On each later accepted sample, group g's counter grows by the number of its mask members whose activity bit is 0, provided at least one member's activity bit is 1. Otherwise it grows by 0, so a group with zero or one member stays at 0.
- R6: Every counter saturates at 2^CNT_W-1 instead of wrapping.
- R7: After T counted samples, `done_o` rises on the same edge as the T-th counted sample and `obs_ready_o` falls on that edge. Results and done then hold, unchanged by further valid samples, until the next start.
- R8: A start with T = 0 raises `done_o` on the next cycle, with all counters at 0 and ready staying 0.
- R9: Read address a in 0..WIDTH-1 returns bit a's toggle count. Address WIDTH+g returns group g's redundant-pulse count. Any other address returns 0. The read is combinational.
- R10: Changes to the mask and window inputs while a window runs have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clear counters and begin a window |
| window_i | input | WIN_W | Number of samples to count (T) |
| grp_mask_i | input | NGRP*WIDTH | Group masks, group g in bits [g*WIDTH +: WIDTH] |
| obs_valid_i | input | 1 | Sample offered |
| obs_i | input | WIDTH | Observed flip-flop values |
| obs_ready_o | output | 1 | Sample will be accepted |
| done_o | output | 1 | Window complete, results stable |
| rd_addr_i | input | ADDR_W | Result select |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
Saturation is the hardest condition to reach from the ports. It needs hundreds of counted samples with a known toggle pattern. The bench narrows the counters to 8 bits and streams a fixed alternating pattern, so that both the per-bit counters and a wide group's counter hit the ceiling well inside one window. Mask and window inputs are changed in the middle of a window, and samples are offered after done, to show that neither reaches the counts.

// File: rtl/tcp_pkg.sv
`timescale 1ns/1ps
package tcp_pkg;
  // Saturating add helper width: enough to hold a count plus one increment.
  function automatic int unsigned sum_w(input int unsigned cnt_w);
    return cnt_w + 1;
  endfunction
endpackage

// File: rtl/tcp_sat_cnt.sv
`timescale 1ns/1ps
module tcp_sat_cnt #(
  parameter int CNT_W = 16,
  parameter int AMT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [CNT_W-1:0] q_o
);
  localparam int SUM_W = tcp_pkg::sum_w(CNT_W);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [SUM_W-1:0] sum;
  always_comb sum = SUM_W'(q_o) + SUM_W'(amt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (en_i)   q_o <= (sum > SUM_W'(MAXV)) ? MAXV : sum[CNT_W-1:0];
  end

  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (q_o >= $past(q_o)));
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o == MAXV && !clr_i) |=> (q_o == MAXV));
endmodule

// File: rtl/tcp_activity.sv
`timescale 1ns/1ps
module tcp_activity #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             fire_i,
  input  logic [WIDTH-1:0] obs_i,
  output logic [WIDTH-1:0] act_o,
  output logic             act_vld_o
);
  logic [WIDTH-1:0] prev_q;
  logic             have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (clr_i) begin
      have_q <= 1'b0;
    end else if (fire_i) begin
      prev_q <= obs_i;
      have_q <= 1'b1;
    end
  end

  assign act_o     = obs_i ^ prev_q;
  assign act_vld_o = fire_i && have_q && !clr_i;

  p_first_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !act_vld_o);
  p_idle_keeps_prev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !clr_i) |=> $stable(prev_q));
endmodule

// File: rtl/tcp_group.sv
`timescale 1ns/1ps
module tcp_group #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             act_vld_i,
  input  logic [WIDTH-1:0] act_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [CNT_W-1:0] waste_o
);
  localparam int AMT_W = $clog2(WIDTH + 1);

  logic             fires;
  logic [AMT_W-1:0] idle_members;

  always_comb begin
    fires = |(act_i & mask_i);
    idle_members = '0;
    for (int i = 0; i < WIDTH; i++)
      idle_members = idle_members + AMT_W'(mask_i[i] & ~act_i[i]);
    if (!fires) idle_members = '0;
  end

  tcp_sat_cnt #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .en_i(act_vld_i),
    .amt_i(idle_members), .q_o(waste_o));

  p_waste_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld_i |-> (32'(idle_members) < 32'($countones(mask_i)) || !fires));
  p_small_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && $countones(mask_i) <= 1) |=> (waste_o == $past(waste_o)));
endmodule

// File: rtl/tcp_window.sv
`timescale 1ns/1ps
module tcp_window #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             act_vld_i,
  output logic             run_o,
  output logic             done_o
);
  logic [WIN_W-1:0] win_q, beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      beats_q <= '0;
      run_o   <= 1'b0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      win_q   <= win_i;
      beats_q <= '0;
      run_o   <= (win_i != '0);
      done_o  <= (win_i == '0);
    end else if (run_o && act_vld_i) begin
      if (beats_q == win_q - 1'b1) begin
        run_o  <= 1'b0;
        done_o <= 1'b1;
      end
      beats_q <= beats_q + 1'b1;
    end
  end

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  p_beats_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (beats_q < win_q));
  p_zero_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && win_i == '0) |=> (done_o && !run_o));
endmodule

// File: rtl/tcp_profiler.sv
`timescale 1ns/1ps
module tcp_profiler #(
  parameter int WIDTH = 16,
  parameter int NGRP  = 4,
  parameter int CNT_W = 16,
  parameter int WIN_W = 16,
  localparam int NRES   = WIDTH + NGRP,
  localparam int ADDR_W = $clog2(NRES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [WIN_W-1:0]      window_i,
  input  logic [NGRP*WIDTH-1:0] grp_mask_i,
  input  logic                  obs_valid_i,
  input  logic [WIDTH-1:0]      obs_i,
  output logic                  obs_ready_o,
  output logic                  done_o,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [CNT_W-1:0]      rd_data_o
);
  logic             run, fire, act_vld;
  logic [WIDTH-1:0] act;
  logic [NGRP-1:0][WIDTH-1:0] mask_q;
  logic [NRES-1:0][CNT_W-1:0] res;

  assign obs_ready_o = run;
  assign fire        = obs_valid_i && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (start_i) mask_q <= grp_mask_i;
  end

  tcp_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .win_i(window_i),
    .act_vld_i(act_vld), .run_o(run), .done_o(done_o));

  tcp_activity #(.WIDTH(WIDTH)) u_act (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .fire_i(fire),
    .obs_i(obs_i), .act_o(act), .act_vld_o(act_vld));

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    tcp_sat_cnt #(.CNT_W(CNT_W), .AMT_W(1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(act_vld),
      .amt_i(act[b]), .q_o(res[b]));
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    tcp_group #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .act_vld_i(act_vld),
      .act_i(act), .mask_i(mask_q[g]), .waste_o(res[WIDTH+g]));
  end

  always_comb begin
    rd_data_o = '0;
    for (int a = 0; a < NRES; a++)
      if (rd_addr_i == ADDR_W'(a)) rd_data_o = res[a];
  end

  p_no_accept_when_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !obs_ready_o);
  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (res[0] == '0 && res[WIDTH] == '0));
endmodule

// File: tb/test_tcp_profiler.sv
`timescale 1ns/1ps
module test_tcp_profiler;
  localparam int W = 16, G = 4, CW = 8, WW = 16;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, start = 0, vld = 0;
  logic [WW-1:0] win = '0;
  logic [G*W-1:0] masks = '0;
  logic [W-1:0] obs = '0;
  logic ready, done;
  logic [4:0] rd_addr = '0;
  logic [CW-1:0] rd_data;

  always #2.5 clk = ~clk;

  tcp_profiler #(.WIDTH(W), .NGRP(G), .CNT_W(CW), .WIN_W(WW)) i_tcp_profiler (
    .clk(clk), .rst_n(rst_n), .start_i(start), .window_i(win),
    .grp_mask_i(masks), .obs_valid_i(vld), .obs_i(obs),
    .obs_ready_o(ready), .done_o(done), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  int n_chk = 0, n_err = 0;
  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int m_bit[W], m_grp[G], m_win, m_beats;
  bit m_run, m_have, m_done;
  logic [W-1:0] m_prev, m_mask[G];

  function automatic int sat(int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  typedef struct { int addr; int val; string tag; } rd_item_t;
  rd_item_t sb[$];

  task automatic push(int a, int v, string tag);
    rd_item_t it;
    it.addr = a; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic push_all(string tb, string tg);
    for (int a = 0; a < W; a++) push(a, m_bit[a], tb);
    for (int g = 0; g < G; g++) push(W + g, m_grp[g], tg);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      wait (sb.size() > 0);
      @(negedge clk);
      rd_addr = 5'(sb[0].addr);
      #1;
      chk(sb[0].tag, int'(rd_data), sb[0].val);
      void'(sb.pop_front());
    end
  end

  task automatic do_start(logic [G*W-1:0] mk, int t);
    start = 1; masks = mk; win = WW'(t);
    @(posedge clk);
    for (int a = 0; a < W; a++) m_bit[a] = 0;
    for (int g = 0; g < G; g++) begin m_grp[g] = 0; m_mask[g] = mk[g*W +: W]; end
    m_win = t; m_beats = 0; m_have = 0;
    m_run = (t != 0); m_done = (t == 0);
    @(negedge clk);
    start = 0;
  endtask

  task automatic step(logic [W-1:0] v, bit valid, string tag);
    logic [W-1:0] a;
    obs = v; vld = valid;
    chk({tag, " ready"}, int'(ready), int'(m_run));
    @(posedge clk);
    if (valid && m_run) begin
      if (m_have) begin
        a = v ^ m_prev;
        for (int i = 0; i < W; i++) m_bit[i] = sat(m_bit[i] + int'(a[i]));
        for (int g = 0; g < G; g++)
          if ((a & m_mask[g]) != '0)
            m_grp[g] = sat(m_grp[g] + $countones(m_mask[g] & ~a));
        m_beats++;
        if (m_beats == m_win) begin m_run = 0; m_done = 1; end
      end
      m_have = 1; m_prev = v;
    end
    @(negedge clk);
    vld = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", int'(done), 0);
    chk("R1 ready", int'(ready), 0);
    for (int a = 0; a < W + G; a++) push(a, 0, "R1");
    drain();
    rst_n = 1;
    @(negedge clk);

    // R3: first beat only captures; R2 ready after start
    do_start({16'h0000, 16'h0001, 16'h00F0, 16'h000F}, 2);
    chk("R2 ready", int'(ready), 1);
    step(16'hAAAA, 1, "R3");
    push_all("R3", "R3");
    drain();
    step(16'h5555, 1, "R4");
    chk("R7 not done", int'(done), 0);
    step(16'h5554, 1, "R7");
    chk("R7 done", int'(done), int'(m_done));
    chk("R7 ready low", int'(ready), 0);
    push_all("R4", "R5");
    drain();

    // random window with gaps, single and empty groups
    do_start({16'h0000, 16'h0100, 16'h03C0, 16'h000F}, 20);
    v = '0;
    for (int k = 0; k < 400 && m_run; k++) begin
      v = 16'($urandom());
      step(v, ($urandom_range(0, 3) != 0), "R4");
    end
    chk("R7 done random", int'(done), 1);
    push_all("R4", "R5");
    push(W + G, 0, "R9"); push(25, 0, "R9"); push(31, 0, "R9");
    drain();
    // R7: samples after done are ignored
    for (int k = 0; k < 5; k++) step(16'($urandom()), 1, "R7");
    chk("R7 hold", int'(done), 1);
    push_all("R7", "R7");
    drain();

    // biased toggles; R10 inputs changed mid-window
    do_start({16'hF000, 16'h8001, 16'hFF00, 16'h00FF}, 150);
    masks = '1; win = 16'd3;
    v = 16'h1234;
    for (int k = 0; k < 1000 && m_run; k++) begin
      for (int i = 0; i < W; i++)
        if ($urandom_range(0, 15) < i) v[i] = ~v[i];
      step(v, ($urandom_range(0, 4) != 0), "R10");
    end
    chk("R10 done", int'(done), 1);
    push_all("R10", "R10");
    drain();

    // R6: saturation with fixed pattern
    do_start({16'h0000, 16'h00FF, 16'h5555, 16'hFFFF}, 300);
    v = 16'h0000;
    for (int k = 0; k < 400 && m_run; k++) begin
      step(v, 1, "R6");
      v = v ^ 16'h5555;
    end
    chk("R6 done", int'(done), 1);
    chk("R6 model sat", m_bit[0], MAXC);
    push_all("R6", "R6");
    drain();

    // R8: zero window
    do_start({G*W{1'b1}}, 0);
    chk("R8 done", int'(done), 1);
    chk("R8 ready", int'(ready), 0);
    step(16'hFFFF, 1, "R8");
    step(16'h0000, 1, "R8");
    push_all("R8", "R8");
    drain();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule